// File: doc/BRIEF.md
# Base Integer Arithmetic and Logic Unit

This block is the purely combinational execute datapath for a 32-bit base integer instruction set. Each evaluation takes the raw 32-bit instruction word, the two source register values and the address of the instruction. From the instruction it forms the operation and the second operand itself, and it returns one 32-bit result. There are no clocks, no state and no side outputs.

It covers add, subtract, signed and unsigned set-less-than, the three logic operations and the three shifts, in both register and immediate forms, plus the two upper-immediate operations. Arithmetic wraps modulo 2^32. No carry, overflow, zero or error indication exists. An instruction word whose major opcode is outside the four handled groups produces zero, so the result of a word that is not for this unit is predictable.

A generate option chooses between a staged logarithmic shifter and a plain operator-based shifter. The shifter is shared by left and right shifts through bit reversal.

Top module: `rv_int_alu`

## Requirements
- R1: With opcode 0010011 (immediate group) or 0110011 (register group) and funct3 000, the result is rs1 plus the second operand modulo 2^32. In the immediate group the second operand is instruction bits 31:20 sign-extended. Word 0x00000013 with rs1 = 0 yields 0.
- R2: In the register group only, with funct3 000, instruction bit 30 set selects rs1 minus rs2 modulo 2^32. In the immediate group bit 30 is an immediate bit and never selects subtraction.
- R3: funct3 010 gives 1 when rs1 < operand B as signed numbers, otherwise 0. funct3 011 gives the same for unsigned numbers, where an immediate is first sign-extended. Bits 31:1 of the result are always 0 for these.
- R4: funct3 001 shifts rs1 left and funct3 101 shifts it right, filling with zeros. For 101, instruction bit 30 set selects an arithmetic right shift that copies bit 31. The amount is the low 5 bits of rs2 (register group) or instruction bits 24:20 (immediate group).
- R5: funct3 100, 110 and 111 give the bitwise XOR, OR and AND of rs1 and operand B, in both groups.
- R6: Opcode 0110111 returns instruction bits 31:12 in result bits 31:12, with bits 11:0 zero.
- R7: Opcode 0010111 returns the instruction address plus the value of R6, modulo 2^32.
- R8: Any other opcode value gives a result of 0.
- R9: Instructions in the immediate group ignore rs2 entirely, and the upper-immediate instructions ignore rs1 and rs2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_word | input | 32 | Full instruction word; opcode, funct3, bit 30 and immediates are taken from it |
| rs1_val | input | 32 | First source register value (operand A) |
| rs2_val | input | 32 | Second source register value, used only by the register group |
| pc_val | input | 32 | Address of the instruction, used by the PC-relative upper-immediate form |
| result | output | 32 | Computed result |

## Verification
Because the block holds no state, any fault shows at the result port in the same evaluation as the input that triggers it. A wrong decode shows as a whole class of results going wrong: for example, using bit 30 as a subtract select in the immediate group, or failing to sign-extend an immediate. A fault in one shifter stage corrupts only those shift amounts that have that amount bit set. The sweeps therefore cover every shift amount and every funct3, with operands at the sign and carry boundaries, so that each such fault appears in at least one vector.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;

   localparam logic [6:0] OPC_REG   = 7'b0110011;
   localparam logic [6:0] OPC_IMM   = 7'b0010011;
   localparam logic [6:0] OPC_LUI   = 7'b0110111;
   localparam logic [6:0] OPC_AUIPC = 7'b0010111;

   typedef enum logic [3:0] {
      OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU, OP_XOR, OP_SRL,
      OP_SRA, OP_OR, OP_AND, OP_LUI, OP_AUIPC, OP_ZERO
   } alu_op_e;

endpackage

// File: rtl/rv_alu_decode.sv
module rv_alu_decode
   import rv_alu_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [31:0]     instr_word,
   output alu_op_e         op,
   output logic            use_imm,
   output logic [XLEN-1:0] imm_i,
   output logic [XLEN-1:0] imm_u
);

   logic [6:0] opcode;
   logic [2:0] f3;
   logic       alt;
   logic       unused_rd;

   assign opcode    = instr_word[6:0];
   assign f3        = instr_word[14:12];
   assign alt       = instr_word[30];
   assign unused_rd = ^instr_word[11:7];

   assign imm_i = {{(XLEN-12){instr_word[31]}}, instr_word[31:20]};
   assign imm_u = {{(XLEN-32){instr_word[31]}}, instr_word[31:12], 12'b0};

   always_comb begin
      op      = OP_ZERO;
      use_imm = 1'b0;
      if (opcode == OPC_REG || opcode == OPC_IMM) begin
         use_imm = (opcode == OPC_IMM);
         case (f3)
            3'b000:  op = (alt && !use_imm) ? OP_SUB : OP_ADD;
            3'b001:  op = OP_SLL;
            3'b010:  op = OP_SLT;
            3'b011:  op = OP_SLTU;
            3'b100:  op = OP_XOR;
            3'b101:  op = alt ? OP_SRA : OP_SRL;
            3'b110:  op = OP_OR;
            default: op = OP_AND;
         endcase
      end else if (opcode == OPC_LUI) begin
         op = OP_LUI;
      end else if (opcode == OPC_AUIPC) begin
         op = OP_AUIPC;
      end
   end

endmodule

// File: rtl/rv_alu_shift.sv
module rv_alu_shift #(
   parameter int XLEN    = 32,
   parameter bit BARREL  = 1'b1,
   localparam int SHW    = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] src,
   input  logic [SHW-1:0]  amt,
   input  logic            go_left,
   input  logic            arith,
   output logic [XLEN-1:0] dst
);

   generate
      if (BARREL) begin : g_staged
         logic [XLEN-1:0] stg [0:SHW];
         logic [XLEN-1:0] fwd;
         logic            fill;

         always_comb begin
            for (int k = 0; k < XLEN; k++)
               fwd[k] = go_left ? src[XLEN-1-k] : src[k];
         end
         assign fill   = arith & ~go_left & src[XLEN-1];
         assign stg[0] = fwd;

         for (genvar s = 0; s < SHW; s++) begin : g_stage
            localparam int D = 1 << s;
            assign stg[s+1] = amt[s] ? {{D{fill}}, stg[s][XLEN-1:D]} : stg[s];
         end

         always_comb begin
            for (int k = 0; k < XLEN; k++)
               dst[k] = go_left ? stg[SHW][XLEN-1-k] : stg[SHW][k];
         end
      end else begin : g_plain
         always_comb begin
            if (go_left)    dst = src << amt;
            else if (arith) dst = $unsigned($signed(src) >>> amt);
            else            dst = src >> amt;
         end
      end
   endgenerate

endmodule

// File: rtl/rv_alu_exec.sv
module rv_alu_exec
   import rv_alu_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter bit BARREL = 1'b1,
   localparam int SHW   = $clog2(XLEN)
) (
   input  alu_op_e         op,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] upper,
   output logic [XLEN-1:0] res
);

   logic [XLEN-1:0] shifted;
   logic            lt_s, lt_u;

   assign lt_s = $signed(opa) < $signed(opb);
   assign lt_u = opa < opb;

   rv_alu_shift #(.XLEN(XLEN), .BARREL(BARREL)) u_shift (
      .src     (opa),
      .amt     (opb[SHW-1:0]),
      .go_left (op == OP_SLL),
      .arith   (op == OP_SRA),
      .dst     (shifted)
   );

   always_comb begin
      case (op)
         OP_ADD:   res = opa + opb;
         OP_SUB:   res = opa - opb;
         OP_SLT:   res = {{(XLEN-1){1'b0}}, lt_s};
         OP_SLTU:  res = {{(XLEN-1){1'b0}}, lt_u};
         OP_XOR:   res = opa ^ opb;
         OP_OR:    res = opa | opb;
         OP_AND:   res = opa & opb;
         OP_SLL, OP_SRL, OP_SRA: res = shifted;
         OP_LUI:   res = upper;
         OP_AUIPC: res = pc + upper;
         default:  res = '0;
      endcase
   end

endmodule

// File: rtl/rv_int_alu.sv
module rv_int_alu
   import rv_alu_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter bit BARREL = 1'b1
) (
   input  logic [31:0]     instr_word,
   input  logic [XLEN-1:0] rs1_val,
   input  logic [XLEN-1:0] rs2_val,
   input  logic [XLEN-1:0] pc_val,
   output logic [XLEN-1:0] result
);

   generate
      if (XLEN < 32 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
         $error("rv_int_alu: XLEN must be a power of two of at least 32");
      end
   endgenerate

   alu_op_e         op;
   logic            use_imm;
   logic [XLEN-1:0] imm_i, imm_u, opb;

   rv_alu_decode #(.XLEN(XLEN)) u_dec (
      .instr_word (instr_word),
      .op         (op),
      .use_imm    (use_imm),
      .imm_i      (imm_i),
      .imm_u      (imm_u)
   );

   assign opb = use_imm ? imm_i : rs2_val;

   rv_alu_exec #(.XLEN(XLEN), .BARREL(BARREL)) u_exec (
      .op    (op),
      .opa   (rs1_val),
      .opb   (opb),
      .pc    (pc_val),
      .upper (imm_u),
      .res   (result)
   );

endmodule

// File: rtl/rv_int_alu_chk.sv
module rv_int_alu_chk #(
   parameter int XLEN = 32
) (
   input logic [31:0]     instr_word,
   input logic [XLEN-1:0] rs1_val,
   input logic [XLEN-1:0] rs2_val,
   input logic [XLEN-1:0] pc_val,
   input logic [XLEN-1:0] result
);

   logic [6:0]      opc;
   logic [2:0]      f3;
   logic [XLEN-1:0] up;
   logic            unused_chk;

   assign opc        = instr_word[6:0];
   assign f3         = instr_word[14:12];
   assign up         = {{(XLEN-32){instr_word[31]}}, instr_word[31:12], 12'b0};
   assign unused_chk = ^instr_word[11:7];

   always_comb begin
      if (opc == 7'b0110111)
         p_lui_shape_r6: assert (result == up);
      if (opc == 7'b0010111)
         p_auipc_offset_r7: assert (result - pc_val == up);
      if (opc != 7'b0110011 && opc != 7'b0010011 &&
          opc != 7'b0110111 && opc != 7'b0010111)
         p_foreign_zero_r8: assert (result == '0);
      if ((opc == 7'b0110011 || opc == 7'b0010011) && f3[2:1] == 2'b01)
         p_compare_bit_r3: assert (result[XLEN-1:1] == '0);
      if (opc == 7'b0110011 && f3 == 3'b000 && instr_word[30])
         p_sub_inverse_r2: assert (result + rs2_val == rs1_val);
      if (opc == 7'b0110011 && f3 == 3'b100)
         p_xor_inverse_r5: assert ((result ^ rs2_val) == rs1_val);
   end

endmodule

bind rv_int_alu rv_int_alu_chk #(.XLEN(XLEN)) u_chk (
   .instr_word (instr_word),
   .rs1_val    (rs1_val),
   .rs2_val    (rs2_val),
   .pc_val     (pc_val),
   .result     (result)
);

// File: tb/rv_int_alu_test.sv
module rv_int_alu_test;

   logic        clk = 1'b0;
   logic [31:0] instr_word = '0;
   logic [31:0] rs1_val = '0;
   logic [31:0] rs2_val = '0;
   logic [31:0] pc_val = '0;
   logic [31:0] result;
   int          n_total = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   rv_int_alu uut (
      .instr_word (instr_word),
      .rs1_val    (rs1_val),
      .rs2_val    (rs2_val),
      .pc_val     (pc_val),
      .result     (result)
   );

   logic [31:0] vals [0:9] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                               32'h8000_0000, 32'h1234_5678, 32'hFEDC_BA98,
                               32'h0000_0020, 32'h8000_0001, 32'h5555_AAAA};
   logic [11:0] imms [0:7] = '{12'h000, 12'h001, 12'hFFF, 12'h7FF,
                               12'h800, 12'h123, 12'hABC, 12'h01F};

   function automatic logic [31:0] ref_model(input logic [31:0] ins,
                                             input logic [31:0] a, b, p);
      logic [31:0] opb, upv;
      upv = {ins[31:12], 12'h000};
      case (ins[6:0])
         7'h33: opb = b;
         7'h13: opb = {{20{ins[31]}}, ins[31:20]};
         7'h37: return upv;
         7'h17: return p + upv;
         default: return 32'h0;
      endcase
      case (ins[14:12])
         3'd0: return (ins[6:0] == 7'h33 && ins[30]) ? a - opb : a + opb;
         3'd1: return a << opb[4:0];
         3'd2: return {31'h0, $signed(a) < $signed(opb)};
         3'd3: return {31'h0, a < opb};
         3'd4: return a ^ opb;
         3'd5: return ins[30] ? $unsigned($signed(a) >>> opb[4:0]) : a >> opb[4:0];
         3'd6: return a | opb;
         default: return a & opb;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] f3, input bit sub);
      case (f3)
         3'd0: return sub ? "R2" : "R1";
         3'd1, 3'd5: return "R4";
         3'd2, 3'd3: return "R3";
         default: return "R5";
      endcase
   endfunction

   task automatic check(input logic [31:0] ins, a, b, p, input string req);
      logic [31:0] exp;
      @(negedge clk);
      instr_word = ins; rs1_val = a; rs2_val = b; pc_val = p;
      #2;
      exp = ref_model(ins, a, b, p);
      n_total++;
      if (result !== exp) begin
         n_fail++;
         $display("FAIL %s instr=%h a=%h b=%h actual=%h expected=%h",
                  req, ins, a, b, result, exp);
      end
   endtask

   task automatic check_val(input logic [31:0] ins, a, b, p, exp,
                            input string req);
      @(negedge clk);
      instr_word = ins; rs1_val = a; rs2_val = b; pc_val = p;
      #2;
      n_total++;
      if (result !== exp) begin
         n_fail++;
         $display("FAIL %s instr=%h actual=%h expected=%h", req, ins, result, exp);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_total++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin
      // Idle inputs: opcode 0000000 is foreign, result 0 (R8)
      check_val(32'h0, 32'h0, 32'h0, 32'h0, 32'h0, "R8");
      // No-op immediate add of zero register (R1)
      check_val(32'h0000_0013, 32'h0, 32'hDEAD_BEEF, 32'h0, 32'h0, "R1");
      check_val({12'hFFF, 5'd1, 3'd0, 5'd3, 7'h13}, 32'h0, 32'h0, 32'h0,
                32'hFFFF_FFFF, "R1");
      check_val({7'h20, 5'd2, 5'd1, 3'd0, 5'd3, 7'h33}, 32'h0, 32'h1, 32'h0,
                32'hFFFF_FFFF, "R2");

      // Register group sweep: every funct3, both bit-30 variants where legal
      for (int f = 0; f < 8; f++) begin
         for (int v = 0; v < 2; v++) begin
            if (v == 1 && f != 0 && f != 5) continue;
            for (int i = 0; i < 10; i++)
               for (int j = 0; j < 10; j++)
                  check({1'b0, v[0], 5'd0, 5'd2, 5'd1, f[2:0], 5'd3, 7'h33},
                        vals[i], vals[j], 32'h0, tag_of(f[2:0], v[0]));
         end
      end

      // Immediate group sweep; bit 30 in ADDI immediate must not subtract (R2)
      for (int f = 0; f < 8; f++) begin
         if (f == 1 || f == 5) continue;
         for (int i = 0; i < 10; i++)
            for (int k = 0; k < 8; k++)
               check({imms[k], 5'd1, f[2:0], 5'd3, 7'h13}, vals[i],
                     32'h0BAD_F00D, 32'h0, tag_of(f[2:0], 1'b0));
      end
      check_val({12'h400, 5'd1, 3'd0, 5'd3, 7'h13}, 32'h10, 32'h0, 32'h0,
                32'h410, "R2");

      // Every shift amount, register and immediate, all three kinds (R4)
      for (int s = 0; s < 32; s++) begin
         for (int i = 2; i < 7; i++) begin
            check({7'h00, 5'd2, 5'd1, 3'd1, 5'd3, 7'h33}, vals[i],
                  {27'h5A5A5A5, s[4:0]}, 32'h0, "R4");
            check({7'h00, 5'd2, 5'd1, 3'd5, 5'd3, 7'h33}, vals[i],
                  {27'h7FFFFFF, s[4:0]}, 32'h0, "R4");
            check({7'h20, 5'd2, 5'd1, 3'd5, 5'd3, 7'h33}, vals[i],
                  {27'h0, s[4:0]}, 32'h0, "R4");
            check({7'h00, s[4:0], 5'd1, 3'd1, 5'd3, 7'h13}, vals[i],
                  32'h0, 32'h0, "R4");
            check({7'h00, s[4:0], 5'd1, 3'd5, 5'd3, 7'h13}, vals[i],
                  32'h0, 32'h0, "R4");
            check({7'h20, s[4:0], 5'd1, 3'd5, 5'd3, 7'h13}, vals[i],
                  32'h0, 32'h0, "R4");
         end
      end
      check_val({7'h20, 5'd4, 5'd1, 3'd5, 5'd3, 7'h13}, 32'h8000_0000, 32'h0,
                32'h0, 32'hF800_0000, "R4");

      // Upper-immediate forms; rs1/rs2 must have no effect (R6, R7, R9)
      for (int i = 0; i < 10; i++) begin
         check({vals[i][19:0], 5'd3, 7'h37}, vals[9 - i], vals[i], 32'h0, "R6");
         check({vals[i][31:12], 5'd3, 7'h17}, vals[i], vals[9 - i],
               vals[(i + 3) % 10], "R7");
      end
      check_val({20'hFFFFF, 5'd3, 7'h17}, 32'h0, 32'h0, 32'h0000_1000,
                32'h0, "R7");
      check_val({20'h80000, 5'd3, 7'h37}, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                32'h0, 32'h8000_0000, "R6");

      // Immediate group ignores rs2 (R9)
      for (int j = 0; j < 10; j++)
         check_val({12'h005, 5'd1, 3'd0, 5'd3, 7'h13}, 32'h100, vals[j],
                   32'h0, 32'h105, "R9");

      // Every foreign opcode yields 0 (R8)
      for (int o = 0; o < 128; o++) begin
         if (o == 7'h33 || o == 7'h13 || o == 7'h37 || o == 7'h17) continue;
         check({25'h1ABCDEF, o[6:0]}, 32'h1234_5678, 32'h0000_0001,
               32'h4000_0000, "R8");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule